// File: doc/BRIEF.md
# Gated Clock Frequency Meter

This block measures the frequency of one clock chosen from a bank of up to 128 source clocks. It counts rising edges of the selected source during a gate window whose length is programmed in microseconds. A prescaler derives a one-cycle microsecond tick from the reference clock, and that tick times the window. The source is resynchronised into the reference domain before counting. Correct counts therefore need the source to run below half the reference frequency.

Software writes a single control word and then polls a busy flag until the count is final. It then reads the count from a second register. A one-shot measurement runs once and stops. A continuous measurement restarts at once after each capture. An optional sticky interrupt flag reports each capture. The conversion from count to rate is left to software. With a 64 µs window, adding 31 to the count and shifting right by 6 gives the rate in MHz.

Top module: `clkm_meter`

## Requirements
- R1: Control bits 15:0 hold N−1. A measurement window lasts exactly N microsecond ticks, which is N×REF_PER_US reference cycles, and every source rising edge detected inside the window is counted.
- R2: Control bit 16 arms a measurement. Writing it low stops any window within one cycle, drops busy, and leaves the result register unchanged.
- R3: With control bit 17 low, the unit makes one measurement and then stays idle until bit 16 is cleared and set again. The result does not change after that single capture.
- R4: With control bit 18 set, a capture sets the `irq` output, and `irq` stays high until a control write has bit 16 low. With bit 18 clear, captures never raise `irq`.
- R5: With control bit 19 clear, no source edges are counted, so a completed window yields a count of 0.
- R6: Control bits 26:20 select which `src_clk` bit is measured.
- R7: Reading the control address (reg_addr = 0) returns bit 31 as busy, bits 26:0 as the last written control bits, and bits 30:27 as 0. Busy is 1 during a gate window. The window begins at the first microsecond tick after the meter is armed.
- R8: Reading the result address (reg_addr = 1) returns the count in its low bits, zero-extended. The count saturates at 2^CNT_W−1 and does not wrap.
- R9: The result register changes only in the cycle in which busy falls.
- R10: In continuous mode (bit 17 set), the next window starts right after each capture, and busy is low for exactly one cycle per capture.
- R11: The microsecond tick occurs once every REF_PER_US reference cycles. Busy is high for N×REF_PER_US cycles in a one-shot window.
- R12: After reset, both registers read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control/status, 1 = result |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| src_clk | input | NSRC | Clocks to be measured |
| irq | output | 1 | Sticky capture interrupt |

## Verification
The hardest situation to reach is a count that saturates while the window is still open. Edges can arrive at most every other reference cycle, so the bench builds the block with a narrow counter and a small prescaler. It then runs a long window on the fastest source. The single-cycle busy gap in continuous mode is also hard to observe. The bench samples busy on every cycle of a long continuous run and measures the length of every low stretch after the first window has started. A cycle-accurate behavioural model runs alongside the design and is compared with it on every clock.

// File: rtl/clkm_pkg.sv
`timescale 1ns/1ps
// Shared types for the clock meter. The control struct is packed so that
// its bit order matches control-word bits 26:0.
package clkm_pkg;
    localparam int GATE_W   = 16;
    localparam int SEL_W    = 7;
    localparam int CTRL_W   = 27;
    localparam int BUSY_BIT = 31;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;       // 26:20 source index
        logic              src_gate;  // 19 pass source to counter
        logic              irq_en;    // 18 capture interrupt enable
        logic              cont;      // 17 continuous mode
        logic              en;        // 16 arm / run
        logic [GATE_W-1:0] gate_len;  // 15:0 window length minus one
    } ctrl_t;

    typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN, ST_DONE} gate_state_e;
endpackage

// File: rtl/clkm_tick_gen.sv
`timescale 1ns/1ps
// Microsecond prescaler: tick_o is high for one cycle out of every DIV.
// Assumes DIV >= 2; the counter runs freely from reset.
module clkm_tick_gen #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    assign tick_o = (pre_q == LAST);

    // Count reference cycles and wrap at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (tick_o) pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_chk
            // R11
            tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/clkm_src_sync.sv
`timescale 1ns/1ps
// Source selection and synchronisation. Picks one source clock, gates it,
// passes it through two flops into the reference domain and flags rising
// edges. Assumes the source runs below half the reference frequency.
module clkm_src_sync #(
    parameter int NSRC  = 128,
    parameter int SEL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_clk,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             gate_en_i,
    output logic             edge_o
);
    logic picked;
    logic s1_q, s2_q, s3_q;

    // Select the source; out-of-range indices read as a quiet line.
    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NSRC; i++)
            if (sel_i == SEL_W'(i)) picked = src_clk[i];
    end

    // Two-flop synchroniser plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= picked & gate_en_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign edge_o = s2_q & ~s3_q;

    // R5
    gated_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(gate_en_i, 2) |-> !edge_o);
endmodule

// File: rtl/clkm_gate_ctl.sv
`timescale 1ns/1ps
// Gate window control, edge counter and result capture. Arms on en_i,
// opens the window on the next tick, counts edges for gate_len_i+1 ticks,
// and captures the saturating count in the cycle that busy falls.
module clkm_gate_ctl #(
    parameter int GATE_W = 16,
    parameter int CNT_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              cont_i,
    input  logic [GATE_W-1:0] gate_len_i,
    input  logic              tick_i,
    input  logic              edge_i,
    output logic              busy_o,
    output logic              capture_o,
    output logic [CNT_W-1:0]  result_o
);
    import clkm_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    gate_state_e       st_q;
    logic [GATE_W-1:0] left_q;
    logic [CNT_W-1:0]  cnt_q, cnt_nxt, res_q;
    logic              busy_q;
    logic              last_tick;

    // Next count, held at the ceiling instead of wrapping.
    assign cnt_nxt   = (edge_i && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
    assign last_tick = tick_i && (left_q == '0);
    assign capture_o = en_i && (st_q == ST_RUN) && last_tick;

    // Window sequencing, counting and capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            busy_q <= 1'b0;
            cnt_q  <= '0;
            left_q <= '0;
            res_q  <= '0;
        end else if (!en_i) begin
            st_q   <= ST_IDLE;
            busy_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: st_q <= ST_ARM;
                ST_ARM: if (tick_i) begin
                    st_q   <= ST_RUN;
                    busy_q <= 1'b1;
                    cnt_q  <= '0;
                    left_q <= gate_len_i;
                end
                ST_RUN: if (last_tick) begin
                    res_q  <= cnt_nxt;
                    busy_q <= 1'b0;
                    cnt_q  <= '0;
                    left_q <= gate_len_i;
                    if (!cont_i) st_q <= ST_DONE;
                end else begin
                    cnt_q  <= cnt_nxt;
                    busy_q <= 1'b1;
                    if (tick_i) left_q <= left_q - 1'b1;
                end
                default: st_q <= ST_DONE;
            endcase
        end
    end

    assign busy_o   = busy_q;
    assign result_o = res_q;

    // R8
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && en_i && cnt_q == CNT_MAX && !tick_i) |=> (cnt_q == CNT_MAX));
    // R9
    result_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_q) |-> $fell(busy_q));
    // R2
    stop_drops_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !busy_q);
endmodule

// File: rtl/clkm_meter.sv
`timescale 1ns/1ps
// Gated clock frequency meter top. Holds the control word and interrupt
// flag, provides the two-address read mux, and wires prescaler, source
// synchroniser and gate controller. Assumes REF_PER_US >= 2, CNT_W <= 20.
module clkm_meter #(
    parameter int NSRC       = 128,
    parameter int REF_PER_US = 250,
    parameter int CNT_W      = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic [NSRC-1:0] src_clk,
    output logic            irq
);
    import clkm_pkg::*;

    ctrl_t            ctrl_q;
    logic             irq_q;
    logic             tick, edge_pulse, busy, capture;
    logic [CNT_W-1:0] result;
    logic             ctrl_wr;

    assign ctrl_wr = reg_wr && !reg_addr;

    // Control register: written only at address 0.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    // Sticky interrupt flag: set on capture, cleared by a write with en low.
    always_ff @(posedge clk) begin
        if (!rst_n)                           irq_q <= 1'b0;
        else if (ctrl_wr && !reg_wdata[16])   irq_q <= 1'b0;
        else if (capture && ctrl_q.irq_en)    irq_q <= 1'b1;
    end

    // Read mux for the two addresses.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr) begin
            reg_rdata[CNT_W-1:0] = result;
        end else begin
            reg_rdata[CTRL_W-1:0] = ctrl_q;
            reg_rdata[BUSY_BIT]   = busy;
        end
    end

    assign irq = irq_q;

    clkm_tick_gen #(.DIV(REF_PER_US)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    clkm_src_sync #(.NSRC(NSRC), .SEL_W(SEL_W)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_clk   (src_clk),
        .sel_i     (ctrl_q.sel),
        .gate_en_i (ctrl_q.src_gate),
        .edge_o    (edge_pulse)
    );

    clkm_gate_ctl #(.GATE_W(GATE_W), .CNT_W(CNT_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (ctrl_q.en),
        .cont_i     (ctrl_q.cont),
        .gate_len_i (ctrl_q.gate_len),
        .tick_i     (tick),
        .edge_i     (edge_pulse),
        .busy_o     (busy),
        .capture_o  (capture),
        .result_o   (result)
    );

    // R4
    irq_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $fell(busy));
endmodule

// File: tb/clkm_meter_test.sv
`timescale 1ns/1ps
module clkm_meter_test;
    localparam int NSRC = 128;
    localparam int DIV  = 8;
    localparam int CW   = 6;
    localparam int MAXC = (1 << CW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic            reg_addr = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NSRC-1:0] src_clk = '0;
    logic            irq;

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;
    logic [31:0] last_ctl = '0, last_res = '0;
    logic last_irq = 1'b0;

    clkm_meter #(.NSRC(NSRC), .REF_PER_US(DIV), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_clk(src_clk), .irq(irq));

    always #2 clk = ~clk;   // 250 MHz

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Source bank: source i toggles every 2 + (i % 7) cycles.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        for (int i = 0; i < NSRC; i++)
            src_clk[i] <= ((cyc / (2 + (i % 7))) % 2) == 1;
    end

    // Behavioural reference model, advanced on each rising edge.
    int m_pre, m_st, m_left, m_cnt, m_res;
    bit m_busy, m_irq, h1, h2, h3;
    logic [26:0] m_ctrl;
    always @(posedge clk) begin
        bit tk, ed, cap;
        int c;
        if (!rst_n) begin
            m_pre = 0; m_st = 0; m_left = 0; m_cnt = 0; m_res = 0;
            m_busy = 0; m_irq = 0; h1 = 0; h2 = 0; h3 = 0; m_ctrl = '0;
        end else begin
            tk = (m_pre == DIV - 1);
            m_pre = tk ? 0 : m_pre + 1;
            ed = h2 && !h3;
            h3 = h2; h2 = h1;
            h1 = src_clk[m_ctrl[26:20]] && m_ctrl[19];
            cap = 0;
            if (!m_ctrl[16]) begin
                m_st = 0; m_busy = 0;
            end else if (m_st == 0) m_st = 1;
            else if (m_st == 1) begin
                if (tk) begin m_st = 2; m_busy = 1; m_cnt = 0; m_left = m_ctrl[15:0]; end
            end else if (m_st == 2) begin
                c = m_cnt + (ed ? 1 : 0);
                if (c > MAXC) c = MAXC;
                if (tk && m_left == 0) begin
                    m_res = c; m_busy = 0; cap = 1; m_cnt = 0; m_left = m_ctrl[15:0];
                    if (!m_ctrl[17]) m_st = 3;
                end else begin
                    m_cnt = c; m_busy = 1;
                    if (tk) m_left = m_left - 1;
                end
            end
            if (reg_wr && !reg_addr && !reg_wdata[16]) m_irq = 0;
            else if (cap && m_ctrl[18]) m_irq = 1;
            if (reg_wr && !reg_addr) m_ctrl = reg_wdata[26:0];
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        #0.2 reg_addr = 1'b1;
        #0.2 last_res = reg_rdata;
        reg_addr = 1'b0;
        #0.2 last_ctl = reg_rdata;
        last_irq = irq;
        if (rst_n) begin
            check(last_ctl[31] == m_busy, "R7 busy", last_ctl[31], m_busy);
            check(last_ctl[26:0] == m_ctrl && last_ctl[30:27] == 0, "R7 ctrl readback", last_ctl, m_ctrl);
            check(last_res == m_res, "R8 result", last_res, m_res);
            check(last_irq == m_irq, "R4 irq", last_irq, m_irq);
        end
    end

    task automatic wr(input logic [31:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    function automatic logic [31:0] cfg(int sel, bit sg, bit ie, bit ct, int glen);
        return (32'(sel) << 20) | (32'(sg) << 19) | (32'(ie) << 18) | (32'(ct) << 17) | (32'd1 << 16) | 32'(glen);
    endfunction

    initial begin
        int hi, falls, run, maxlow, prev_res;
        bit started, pb;
        step(5);
        rst_n = 1'b1;
        step(1);
        // R12 reset state
        check(last_ctl == 0, "R12 ctrl after reset", last_ctl, 0);
        check(last_res == 0, "R12 result after reset", last_res, 0);
        check(last_irq == 0, "R12 irq after reset", last_irq, 0);

        // R1 / R11 one-shot on period-4 source, N=4 ticks -> 32 cycles, 8 edges
        wr(cfg(7, 1, 0, 0, 3));
        hi = 0;
        for (int i = 0; i < 60; i++) begin step(1); if (last_ctl[31]) hi++; end
        check(hi == 4 * DIV, "R11 busy length", hi, 4 * DIV);
        check(last_res == 8, "R1 window count", last_res, 8);
        // R3 one-shot stays idle
        step(80);
        check(last_res == 8 && !last_ctl[31], "R3 no rerun", last_res, 8);
        // R2 stop keeps result
        wr(0);
        step(2);
        check(last_res == 8, "R2 result kept", last_res, 8);

        // R6 select source 5 (period 14), N=7 -> 56 cycles, 4 edges
        wr(cfg(5, 1, 0, 0, 6));
        step(80);
        check(last_res == 4, "R6 source select", last_res, 4);
        wr(0);

        // R5 source gate off
        wr(cfg(7, 0, 0, 0, 3));
        step(60);
        check(last_res == 0, "R5 gated source", last_res, 0);
        wr(0);

        // R8 saturation: N=32 -> 64 edges, counter ceiling 63
        wr(cfg(7, 1, 0, 0, 31));
        step(32 * DIV + 30);
        check(last_res == MAXC, "R8 saturation", last_res, MAXC);
        wr(0);

        // R10 / R4 continuous with interrupt, source 4 (period 12), N=3
        wr(cfg(4, 1, 1, 1, 2));
        falls = 0; run = 0; maxlow = 0; started = 0; pb = 0;
        for (int i = 0; i < 240; i++) begin
            step(1);
            if (last_ctl[31]) begin
                if (started && run > maxlow) maxlow = run;
                started = 1; run = 0;
            end else if (started) begin
                run++;
            end
            if (pb && !last_ctl[31]) falls++;
            pb = last_ctl[31];
        end
        check(falls >= 8, "R10 repeated captures", falls, 8);
        check(maxlow == 1, "R10 one-cycle busy gap", maxlow, 1);
        check(last_res == 2, "R10 continuous count", last_res, 2);
        check(last_irq == 1, "R4 irq set", last_irq, 1);
        wr(0);
        step(1);
        check(last_irq == 0, "R4 irq cleared", last_irq, 0);
        check(!last_ctl[31], "R2 stop drops busy", last_ctl[31], 0);

        // R4 no irq when disabled
        wr(cfg(7, 1, 0, 0, 1));
        step(40);
        check(last_irq == 0, "R4 irq masked", last_irq, 0);
        wr(0);

        // R2 / R7 stop mid-window
        prev_res = last_res;
        wr(cfg(7, 1, 0, 0, 31));
        step(50);
        check(last_ctl[31] == 1, "R7 busy in window", last_ctl[31], 1);
        wr(0);
        step(2);
        check(!last_ctl[31], "R2 aborted busy", last_ctl[31], 0);
        check(last_res == prev_res, "R2 aborted result kept", last_res, prev_res);
        // R9 result only moves on busy fall: covered per-cycle by model and here
        step(40);
        check(last_res == prev_res, "R9 result stable while idle", last_res, prev_res);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule